// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This block holds two independent down-counters behind a small word-wide register bus. Each counter has a reload register and a live value register. A shared control word gives each counter a run bit and a rearm bit. When the rearm bit is set, a counter that reaches zero loads its reload value and keeps going, so it produces a periodic tick. When the rearm bit is clear, the counter fires once, parks at zero and clears its own run bit.

Software starts a countdown by writing the value register directly. It then sets the run bit. Each counter drives its own interrupt line, which pulses for one clock per expiry. A typical setup uses one counter as a free-running time base, with the reload register set to all ones. The other counter is used as an event timer, in one-shot or periodic mode.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the control word, both reload registers and both value registers read zero, and both interrupt lines are low.
- R2: The register map is fixed by address:
  - Control is at 0x00. Bit 0 is timer 0 run, bit 1 is timer 0 rearm, bit 2 is timer 1 run, bit 3 is timer 1 rearm.
  - Timer 0 reload is at 0x10 and timer 0 value is at 0x14. Timer 1 reload is at 0x18 and timer 1 value is at 0x1C.
  - A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high.
  - Read data is combinational while `bus_sel` is high and `bus_wr` is low. Control bits above bit 3 read zero.
- R3: While its run bit is set and its count is non-zero, a counter decreases by exactly one per clock. The value register reads the live count.
- R4: A running counter with its rearm bit set that sits at zero loads its reload value R on the next clock. Its expiries then come every R+1 clocks.
- R5: An expiry is a clock edge at which a counter's run bit is set, its count is zero, and its value register is not being written. The interrupt line of that timer is high for the one clock that follows each expiry edge.
- R6: Write value V, then set the run bit (rearm clear) with a control write at edge E. The interrupt is then high in the clock after edge E+V+1. This holds for every V from 0 up to the all-ones count.
- R7: After a one-shot expiry the count stays at zero and the run bit reads zero. The rearm bit is unchanged, and the interrupt pulse lasts a single clock.
- R8: A write to a value register loads the counter directly. It takes priority over both decrementing and expiry, and the next countdown starts from the written value.
- R9: While its run bit is clear, a counter holds its count unchanged.
- R10: Writes to any address other than the five mapped ones change no register. Reads from such addresses return zero.
- R11: Each timer's counting and interrupt are unaffected by the other timer's activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every clock is one count tick |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational |
| tmr_irq | output | 2 | Per-timer expiry pulse, bit i for timer i |

## Verification
The bench builds the block with `CNT_W = 8` and the default 5-bit address. With this width, the whole count range of a timer is cheap to walk. The one-shot latency is swept over every start value from 0 to 40 and also at the all-ones value 255. The periodic interval is swept over reload values 0 to 15, alternating the two timers. Every mapped and several unmapped addresses are exercised. Expected latencies and counts are worked out in the bench from V+1 and R+1.

// File: rtl/drt_pkg.sv
package drt_pkg;
    localparam int unsigned NUM_TMR = 2;
    localparam int unsigned CTL_W   = 2 * NUM_TMR;

    localparam logic [4:0] OFF_CTRL = 5'h00;
    localparam logic [4:0] OFF_BASE = 5'h10;

    // reload register of timer i
    function automatic logic [4:0] rld_off(input int i);
        return OFF_BASE + 5'(8 * i);
    endfunction

    // live value register of timer i
    function automatic logic [4:0] val_off(input int i);
        return OFF_BASE + 5'(8 * i + 4);
    endfunction
endpackage

// File: rtl/drt_regdecode.sv
module drt_regdecode
    import drt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [CTL_W-1:0]                 ctl,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]    rld,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]    cnt,
    output logic                             ctl_wr,
    output logic [NUM_TMR-1:0]               rld_wr,
    output logic [NUM_TMR-1:0]               val_wr,
    output logic [CNT_W-1:0]                 rdata
);
    logic wr_en;
    logic rd_en;

    always_comb begin
        wr_en  = bus_sel && bus_wr;
        rd_en  = bus_sel && !bus_wr;
        ctl_wr = wr_en && (bus_addr == ADDR_W'(OFF_CTRL));
        rld_wr = '0;
        val_wr = '0;
        rdata  = '0;
        if (rd_en && (bus_addr == ADDR_W'(OFF_CTRL))) begin
            rdata[CTL_W-1:0] = ctl;
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            rld_wr[i] = wr_en && (bus_addr == ADDR_W'(rld_off(i)));
            val_wr[i] = wr_en && (bus_addr == ADDR_W'(val_off(i)));
            if (rd_en && (bus_addr == ADDR_W'(rld_off(i)))) begin
                rdata = rld[i];
            end
            if (rd_en && (bus_addr == ADDR_W'(val_off(i)))) begin
                rdata = cnt[i];
            end
        end
    end
endmodule

// File: rtl/drt_channel.sv
module drt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rearm,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   expire;

    always_comb begin
        st_d   = st_q;
        expire = run && (st_q.cnt == '0) && !load_we;
        st_d.irq = expire;
        if (load_we) begin
            st_d.cnt = load_val;
        end else if (expire) begin
            if (rearm) begin
                st_d.cnt = rld_val;
            end
        end else if (run) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        done = expire && !rearm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign irq = st_q.irq;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [CNT_W-1:0]             bus_wdata,
    output logic [CNT_W-1:0]             bus_rdata,
    output logic [drt_pkg::NUM_TMR-1:0]  tmr_irq
);
    import drt_pkg::*;

    typedef struct packed {
        logic [CTL_W-1:0]              ctl;
        logic [NUM_TMR-1:0][CNT_W-1:0] rld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                          ctl_wr_w;
    logic [NUM_TMR-1:0]            rld_wr_w;
    logic [NUM_TMR-1:0]            val_wr_w;
    logic [NUM_TMR-1:0]            run_w;
    logic [NUM_TMR-1:0]            rearm_w;
    logic [NUM_TMR-1:0]            done_w;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_TMR-1:0][CNT_W-1:0] rld_w;

    drt_regdecode #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .ctl      (st_q.ctl),
        .rld      (st_q.rld),
        .cnt      (cnt_w),
        .ctl_wr   (ctl_wr_w),
        .rld_wr   (rld_wr_w),
        .val_wr   (val_wr_w),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        assign run_w[i]   = st_q.ctl[2*i];
        assign rearm_w[i] = st_q.ctl[2*i+1];
        assign rld_w[i]   = st_q.rld[i];

        drt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_w[i]),
            .rearm    (rearm_w[i]),
            .load_we  (val_wr_w[i]),
            .load_val (bus_wdata),
            .rld_val  (st_q.rld[i]),
            .cnt      (cnt_w[i]),
            .irq      (tmr_irq[i]),
            .done     (done_w[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (ctl_wr_w) begin
            st_d.ctl = bus_wdata[CTL_W-1:0];
        end else begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (done_w[i]) begin
                    st_d.ctl[2*i] = 1'b0;
                end
            end
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (rld_wr_w[i]) begin
                st_d.rld[i] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctl_wr,
    input logic [1:0]            run,
    input logic [1:0]            rearm,
    input logic [1:0]            val_wr,
    input logic [1:0][CNT_W-1:0] cnt,
    input logic [1:0][CNT_W-1:0] rld,
    input logic [1:0]            irq
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && cnt[i] != '0 && !val_wr[i]) |=> (cnt[i] == $past(cnt[i]) - CNT_W'(1))); // R3

        AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && cnt[i] == '0 && rearm[i] && !val_wr[i]) |=> (cnt[i] == $past(rld[i]))); // R4

        AST_IRQ_FOLLOWS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(run[i] && cnt[i] == '0 && !val_wr[i])); // R5

        AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && cnt[i] == '0 && !rearm[i] && !val_wr[i] && !ctl_wr) |=> (!run[i] && cnt[i] == '0)); // R7

        AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !val_wr[i]) |=> $stable(cnt[i])); // R9
    end
endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W)) u_drt_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (ctl_wr_w),
    .run    (run_w),
    .rearm  (rearm_w),
    .val_wr (val_wr_w),
    .cnt    (cnt_w),
    .rld    (rld_w),
    .irq    (tmr_irq)
);

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
    localparam int W  = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [1:0]    tmr_irq;

    int nchk = 0;
    int nfail = 0;

    dual_reload_timer #(.CNT_W(W), .ADDR_W(AW)) u_dual_reload_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output int d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(input int t, output int n, output bit other);
        n = 0; other = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (tmr_irq[1-t]) other = 1'b1;
        end while (!tmr_irq[t] && n < 2000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int d, n;
        bit other;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h00, d); chk("R1 ctrl", d, 0);
        bus_read(5'h10, d); chk("R1 rld0", d, 0);
        bus_read(5'h14, d); chk("R1 val0", d, 0);
        bus_read(5'h18, d); chk("R1 rld1", d, 0);
        bus_read(5'h1C, d); chk("R1 val1", d, 0);
        chk("R1 irq", int'(tmr_irq), 0);

        // R2 map and readback
        bus_write(5'h00, 8'h0A); bus_read(5'h00, d); chk("R2 ctrl", d, 8'h0A);
        bus_write(5'h00, 8'hFA); bus_read(5'h00, d); chk("R2 ctrl upper", d, 8'h0A);
        bus_write(5'h10, 8'h5A); bus_read(5'h10, d); chk("R2 rld0", d, 8'h5A);
        bus_write(5'h18, 8'hA5); bus_read(5'h18, d); chk("R2 rld1", d, 8'hA5);
        bus_write(5'h00, 8'h00);

        // R10 unmapped addresses
        for (int a = 0; a < 32; a++) begin
            if (a != 0 && a != 16 && a != 20 && a != 24 && a != 28) begin
                bus_write(5'(a), 8'hFF);
                bus_read(5'(a), d); chk("R10 reserved read", d, 0);
            end
        end
        bus_read(5'h00, d); chk("R10 ctrl kept", d, 0);
        bus_read(5'h10, d); chk("R10 rld0 kept", d, 8'h5A);
        bus_read(5'h14, d); chk("R10 val0 kept", d, 0);
        bus_read(5'h18, d); chk("R10 rld1 kept", d, 8'hA5);
        bus_read(5'h1C, d); chk("R10 val1 kept", d, 0);

        // R6 R7 R11 one-shot sweep
        for (int v = 0; v <= 41; v++) begin
            int vv = (v == 41) ? 255 : v;
            int t  = v % 2;
            bus_write(5'(20 + 8*t), 8'(vv));
            bus_write(5'h00, 8'(1 << (2*t)));
            wait_irq(t, n, other);
            chk("R6 one-shot latency", n, vv + 1);
            chk("R11 other irq quiet", int'(other), 0);
            @(negedge clk);
            chk("R7 single pulse", int'(tmr_irq[t]), 0);
            bus_read(5'h00, d); chk("R7 run cleared", d, 0);
            bus_read(5'(20 + 8*t), d); chk("R7 count parked", d, 0);
        end

        // R4 R5 periodic sweep
        for (int r = 0; r < 16; r++) begin
            int t = r % 2;
            bus_write(5'(16 + 8*t), 8'(r));
            bus_write(5'(20 + 8*t), 8'(r));
            bus_write(5'h00, 8'(3 << (2*t)));
            wait_irq(t, n, other);
            chk("R5 first expiry", n, r + 1);
            for (int k = 0; k < 2; k++) begin
                wait_irq(t, n, other);
                chk("R4 period", n, r + 1);
            end
            chk("R11 other irq quiet", int'(other), 0);
            bus_write(5'h00, 8'h00);
            repeat (3) @(negedge clk);
        end
        bus_read(5'h00, d); chk("R4 rearm kept after stop", d, 0);

        // R3 live decrement
        bus_write(5'h10, 8'hFF);
        bus_write(5'h14, 8'hFF);
        bus_write(5'h00, 8'h03);
        bus_read(5'h14, d); chk("R3 first read", d, 8'hFF);
        @(negedge clk);
        bus_read(5'h14, d); chk("R3 second read", d, 8'hFE);

        // R9 freeze on stop
        repeat (8) @(negedge clk);
        bus_write(5'h00, 8'h00);
        repeat (10) @(negedge clk);
        bus_read(5'h14, d); chk("R9 held count", d, 8'hF5);
        chk("R9 no irq", int'(tmr_irq), 0);

        // R8 direct load mid-count
        bus_write(5'h10, 8'd50);
        bus_write(5'h14, 8'd50);
        bus_write(5'h00, 8'h03);
        repeat (5) @(negedge clk);
        bus_write(5'h14, 8'd5);
        wait_irq(0, n, other);
        chk("R8 reload mid-count", n, 6);
        bus_write(5'h00, 8'h00);
        repeat (3) @(negedge clk);

        // R8 value write beats a pending expiry
        bus_write(5'h1C, 8'd0);
        bus_write(5'h00, 8'h04);
        bus_write(5'h1C, 8'd3);
        wait_irq(1, n, other);
        chk("R8 write beats expiry", n, 4);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule